// File: doc/BRIEF.md
# Execution mask divergence controller

This block is the scalar control unit that steers if/else divergence for a 64-lane wavefront. It holds the execute mask, which selects the lanes that take part in vector work. It also holds a condition mask, which a vector compare fills in, and a small bank of 64-bit scalar registers. Software-style micro-operations act on these masks. They can park the execute mask in a scalar register, narrow it to the lanes whose condition held, flip it to the complementary lanes for the else path, and bring it back afterwards.

Two conditional branches let the sequencer skip a code region when no lane would run it. One is taken when the condition mask is empty and the other when the execute mask is empty. A branch resolves in the cycle it is issued, so the fetch logic sees the taken flag and target without delay. Mask operations update state on the clock edge that ends their issue cycle, and the next operation sees the new value.

Top module: `exec_mask_ctrl`

## Requirements
- R1: After reset the execute mask is all ones, the condition mask is zero and every scalar register holds zero.
- R2: Opcode 1 (compare) writes the condition mask with the per-lane compare input ANDed with the execute mask, so inactive lanes get 0; the execute mask is unchanged.
- R3: Opcode 2 (save) copies the execute mask into scalar register `sreg_dst_i`; both masks are unchanged.
- R4: Opcode 3 (enter if) sets the execute mask to the condition mask ANDed with the execute mask.
- R5: Opcode 4 (enter else) sets the execute mask to scalar register `sreg_src_i` ANDed with the inverse of the current execute mask.
- R6: Opcode 5 (restore) loads the execute mask from scalar register `sreg_src_i`.
- R7: Opcode 6 (branch on empty condition) raises `br_taken_o` in the same cycle, with `br_target_o` equal to `target_i`, exactly when the condition mask is all zero.
- R8: Opcode 7 (branch on empty execute mask) raises `br_taken_o` in the same cycle, with `br_target_o` equal to `target_i`, exactly when the execute mask is all zero.
- R9: When no branch is taken, `br_taken_o` is 0 and `br_target_o` is 0.
- R10: With `op_valid_i` low, no mask or scalar register changes and no branch is taken, whatever the other inputs are.
- R11: Opcode 0 and opcodes 8 to 15 change no state and take no branch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_valid_i | input | 1 | A micro-operation is issued this cycle |
| op_code_i | input | 4 | Operation code |
| sreg_dst_i | input | 3 | Scalar register written by save |
| sreg_src_i | input | 3 | Scalar register read by else and restore |
| cmp_result_i | input | 64 | Per-lane compare outcome |
| target_i | input | 16 | Branch target address |
| exec_o | output | 64 | Current execute mask |
| vcc_o | output | 64 | Current condition mask |
| br_taken_o | output | 1 | Branch taken this cycle |
| br_target_o | output | 16 | Target of the taken branch, 0 otherwise |

## Verification
The bench runs the full if/else idiom three ways: with a mixed condition, with every lane failing so the if-branch must fire, and with every lane passing so the else-branch must fire. A design that tests the wrong mask for either branch would fall into an empty region or skip a live one. It nests a second save inside the if path. A register bank that aliased entries or wrote on the wrong index would then restore a corrupted outer mask. Compares issued under a narrowed mask, idle cycles and unused opcodes carrying noise on every input catch condition bits leaking from inactive lanes and state that moves without a valid operation.

// File: rtl/exec_mask_pkg.sv
package exec_mask_pkg;
  typedef enum logic [3:0] {
    OP_NOP     = 4'd0,
    OP_CMP     = 4'd1,
    OP_SAVE    = 4'd2,
    OP_AND_VCC = 4'd3,
    OP_ELSE    = 4'd4,
    OP_RESTORE = 4'd5,
    OP_BR_VCCZ = 4'd6,
    OP_BR_EXEZ = 4'd7
  } op_e;
endpackage

// File: rtl/sreg_bank.sv
module sreg_bank #(
  parameter int LANES    = 64,
  parameter int NUM_SREG = 8,
  localparam int IDX_W   = $clog2(NUM_SREG)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] waddr_i,
  input  logic [LANES-1:0] wdata_i,
  input  logic [IDX_W-1:0] raddr_i,
  output logic [LANES-1:0] rdata_o
);
  logic [LANES-1:0] regs_q [NUM_SREG];

  for (genvar g = 0; g < NUM_SREG; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               regs_q[g] <= '0;
      else if (we_i && waddr_i == IDX_W'(g))     regs_q[g] <= wdata_i;
    end

    AST_SREG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(we_i && waddr_i == IDX_W'(g)) |=> $stable(regs_q[g])); // R10
  end

  assign rdata_o = regs_q[raddr_i];
endmodule

// File: rtl/mask_alu.sv
module mask_alu
  import exec_mask_pkg::*;
#(
  parameter int LANES = 64
) (
  input  logic             valid_i,
  input  op_e              op_i,
  input  logic [LANES-1:0] exec_i,
  input  logic [LANES-1:0] vcc_i,
  input  logic [LANES-1:0] cmp_i,
  input  logic [LANES-1:0] sreg_i,
  output logic [LANES-1:0] exec_nxt_o,
  output logic [LANES-1:0] vcc_nxt_o,
  output logic             save_o
);
  always_comb begin
    exec_nxt_o = exec_i;
    vcc_nxt_o  = vcc_i;
    save_o     = 1'b0;
    if (valid_i) begin
      unique case (op_i)
        OP_CMP:     vcc_nxt_o  = cmp_i & exec_i;   // inactive lanes read 0
        OP_SAVE:    save_o     = 1'b1;
        OP_AND_VCC: exec_nxt_o = vcc_i & exec_i;
        OP_ELSE:    exec_nxt_o = sreg_i & ~exec_i;
        OP_RESTORE: exec_nxt_o = sreg_i;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/branch_unit.sv
module branch_unit
  import exec_mask_pkg::*;
#(
  parameter int LANES  = 64,
  parameter int ADDR_W = 16
) (
  input  logic              valid_i,
  input  op_e               op_i,
  input  logic [LANES-1:0]  exec_i,
  input  logic [LANES-1:0]  vcc_i,
  input  logic [ADDR_W-1:0] target_i,
  output logic              taken_o,
  output logic [ADDR_W-1:0] target_o
);
  logic vcc_zero, exec_zero;
  assign vcc_zero  = ~|vcc_i;
  assign exec_zero = ~|exec_i;

  always_comb begin
    taken_o = 1'b0;
    if (valid_i) begin
      unique case (op_i)
        OP_BR_VCCZ: taken_o = vcc_zero;
        OP_BR_EXEZ: taken_o = exec_zero;
        default: ;
      endcase
    end
  end

  assign target_o = taken_o ? target_i : '0;
endmodule

// File: rtl/exec_mask_ctrl.sv
module exec_mask_ctrl
  import exec_mask_pkg::*;
#(
  parameter int LANES    = 64,
  parameter int NUM_SREG = 8,
  parameter int ADDR_W   = 16,
  localparam int IDX_W   = $clog2(NUM_SREG)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              op_valid_i,
  input  logic [3:0]        op_code_i,
  input  logic [IDX_W-1:0]  sreg_dst_i,
  input  logic [IDX_W-1:0]  sreg_src_i,
  input  logic [LANES-1:0]  cmp_result_i,
  input  logic [ADDR_W-1:0] target_i,
  output logic [LANES-1:0]  exec_o,
  output logic [LANES-1:0]  vcc_o,
  output logic              br_taken_o,
  output logic [ADDR_W-1:0] br_target_o
);
  op_e              op;
  logic [LANES-1:0] exec_q, vcc_q, exec_d, vcc_d, sreg_rd;
  logic             save;

  assign op = op_e'(op_code_i);

  sreg_bank #(.LANES(LANES), .NUM_SREG(NUM_SREG)) u_sreg (
    .clk_i, .rst_ni,
    .we_i(save), .waddr_i(sreg_dst_i), .wdata_i(exec_q),
    .raddr_i(sreg_src_i), .rdata_o(sreg_rd)
  );

  mask_alu #(.LANES(LANES)) u_alu (
    .valid_i(op_valid_i), .op_i(op), .exec_i(exec_q), .vcc_i(vcc_q),
    .cmp_i(cmp_result_i), .sreg_i(sreg_rd),
    .exec_nxt_o(exec_d), .vcc_nxt_o(vcc_d), .save_o(save)
  );

  branch_unit #(.LANES(LANES), .ADDR_W(ADDR_W)) u_br (
    .valid_i(op_valid_i), .op_i(op), .exec_i(exec_q), .vcc_i(vcc_q),
    .target_i, .taken_o(br_taken_o), .target_o(br_target_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exec_q <= '1;
      vcc_q  <= '0;
    end else begin
      exec_q <= exec_d;
      vcc_q  <= vcc_d;
    end
  end

  assign exec_o = exec_q;
  assign vcc_o  = vcc_q;

  AST_CMP_INACTIVE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_code_i == 4'd1) |=> (vcc_q & ~$past(exec_q)) == '0); // R2
  AST_SAVE_KEEPS_MASKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_code_i == 4'd2) |=> $stable(exec_q) && $stable(vcc_q)); // R3
  AST_IF_NARROWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_code_i == 4'd3) |=> (exec_q & ~$past(exec_q)) == '0); // R4
  AST_ELSE_DISJOINT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_code_i == 4'd4) |=> (exec_q & $past(exec_q)) == '0); // R5
  AST_VCCZ_ONLY_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (br_taken_o && op_code_i == 4'd6) |-> vcc_o == '0); // R7
  AST_EXECZ_ONLY_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (br_taken_o && op_code_i == 4'd7) |-> exec_o == '0); // R8
  AST_NO_TARGET_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !br_taken_o |-> br_target_o == '0); // R9
  AST_IDLE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !op_valid_i |=> $stable(exec_q) && $stable(vcc_q)); // R10
  AST_IDLE_NO_BRANCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !op_valid_i |-> !br_taken_o); // R10
  AST_UNUSED_OPS_INERT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && (op_code_i == 4'd0 || op_code_i >= 4'd8))
      |=> $stable(exec_q) && $stable(vcc_q)); // R11
endmodule

// File: tb/exec_mask_ctrl_test.sv
module exec_mask_ctrl_test;
  localparam int OP_NOP = 0, OP_CMP = 1, OP_SAVE = 2, OP_IF = 3, OP_ELSE = 4,
                 OP_RESTORE = 5, OP_BVZ = 6, OP_BEZ = 7;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [3:0]  op_code = '0;
  logic [2:0]  dst = '0, src = '0;
  logic [63:0] cmp = '0;
  logic [15:0] tgt = '0;
  logic [63:0] exec_o, vcc_o;
  logic        br_taken;
  logic [15:0] br_target;

  logic [63:0] m_exec, m_vcc;
  logic [63:0] m_sreg [8];
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  exec_mask_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .op_valid_i(op_valid), .op_code_i(op_code),
    .sreg_dst_i(dst), .sreg_src_i(src), .cmp_result_i(cmp), .target_i(tgt),
    .exec_o(exec_o), .vcc_o(vcc_o), .br_taken_o(br_taken), .br_target_o(br_target)
  );

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic string req_of(bit v, int op);
    if (!v) return "R10";
    case (op)
      OP_CMP: return "R2";  OP_SAVE: return "R3";  OP_IF: return "R4";
      OP_ELSE: return "R5"; OP_RESTORE: return "R6"; OP_BVZ: return "R7";
      OP_BEZ: return "R8";  default: return "R11";
    endcase
  endfunction

  // one issue cycle: check state, drive, check branch, advance model
  task automatic step(bit v, int op, int d, int s, logic [63:0] c, logic [15:0] t);
    string rq;
    bit exp_tk;
    rq = req_of(v, op);
    @(negedge clk);
    check(exec_o == m_exec, rq, "exec mask", exec_o, m_exec);
    check(vcc_o == m_vcc, rq, "cond mask", vcc_o, m_vcc);
    op_valid = v; op_code = 4'(op); dst = 3'(d); src = 3'(s); cmp = c; tgt = t;
    #1;
    exp_tk = v && ((op == OP_BVZ && m_vcc == 0) || (op == OP_BEZ && m_exec == 0));
    check(br_taken == exp_tk, (op == OP_BVZ || op == OP_BEZ) ? rq : "R9",
          "branch taken", 64'(br_taken), 64'(exp_tk));
    check(br_target == (exp_tk ? t : 16'h0), exp_tk ? rq : "R9",
          "branch target", 64'(br_target), 64'(exp_tk ? t : 16'h0));
    @(posedge clk);
    if (v) begin
      case (op)
        OP_CMP:     m_vcc = c & m_exec;
        OP_SAVE:    m_sreg[d] = m_exec;
        OP_IF:      m_exec = m_vcc & m_exec;
        OP_ELSE:    m_exec = m_sreg[s] & ~m_exec;
        OP_RESTORE: m_exec = m_sreg[s];
        default: ;
      endcase
    end
  endtask

  // if/else idiom with a given compare pattern
  task automatic if_else(logic [63:0] c, int sr);
    step(1, OP_CMP, 0, 0, c, 0);
    step(1, OP_SAVE, sr, 0, 0, 0);
    step(1, OP_IF, 0, 0, 0, 0);
    step(1, OP_BVZ, 0, 0, 0, 16'h0040);
    step(1, OP_ELSE, 0, sr, 0, 0);
    step(1, OP_BEZ, 0, 0, 0, 16'h0080);
    step(1, OP_RESTORE, 0, sr, 0, 0);
  endtask

  initial begin
    m_exec = '1; m_vcc = '0;
    for (int i = 0; i < 8; i++) m_sreg[i] = '0;
    repeat (3) @(posedge clk);
    #2;
    check(exec_o == '1, "R1", "reset exec", exec_o, '1);
    check(vcc_o == '0, "R1", "reset cond", vcc_o, '0);
    rst_n = 1'b1;
    // R1: every scalar register reads zero after reset
    for (int i = 0; i < 8; i++) begin
      step(1, OP_RESTORE, 0, i, 0, 0);
      step(1, OP_RESTORE, 0, 0, 0, 0);
      step(1, OP_BEZ, 0, 0, 0, 16'h1111);
    end
    m_exec = m_exec; // model already tracks zero mask
    step(1, OP_RESTORE, 0, 0, 0, 0);
    // restore all ones: save from a fresh compare path
    step(1, OP_CMP, 0, 0, '1, 0);           // R2 with empty exec -> vcc 0
    step(1, OP_BVZ, 0, 0, 0, 16'h2222);     // R7 taken
    // reset again to get exec all ones
    @(negedge clk); rst_n = 1'b0; op_valid = 1'b0;
    #2;
    m_exec = '1; m_vcc = '0;
    for (int i = 0; i < 8; i++) m_sreg[i] = '0;
    @(negedge clk); rst_n = 1'b1;

    if_else(64'hF0F0_1234_0000_FFFF, 0);    // mixed
    if_else(64'h0, 1);                       // R7 taken
    if_else(64'hFFFF_FFFF_FFFF_FFFF, 2);     // R8 taken
    // nested: narrowed compare then inner save (R2 inactive lanes, R3)
    step(1, OP_CMP, 0, 0, 64'h00FF_00FF_00FF_00FF, 0);
    step(1, OP_SAVE, 3, 0, 0, 0);
    step(1, OP_IF, 0, 0, 0, 0);
    step(1, OP_CMP, 0, 0, 64'hFFFF_0000_FFFF_000F, 0);
    step(1, OP_SAVE, 4, 0, 0, 0);
    step(1, OP_IF, 0, 0, 0, 0);
    step(1, OP_ELSE, 0, 4, 0, 0);
    step(1, OP_RESTORE, 0, 4, 0, 0);
    step(1, OP_RESTORE, 0, 3, 0, 0);
    // idle and unused opcodes with noise
    for (int i = 0; i < 16; i++) begin
      step(0, i, i % 8, (i + 3) % 8, {$urandom, $urandom}, 16'($urandom));
      step(1, (i < 8) ? 0 : i, i % 8, 7, {$urandom, $urandom}, 16'($urandom));
    end
    for (int i = 0; i < 8; i++) step(1, OP_RESTORE, 0, i, 0, 0);
    // random mix
    for (int i = 0; i < 300; i++)
      step($urandom_range(0, 9) != 0, $urandom_range(0, 15), $urandom_range(0, 7),
           $urandom_range(0, 7), ($urandom_range(0, 3) == 0) ? 64'h0 : {$urandom, $urandom},
           16'($urandom));
    step(0, 0, 0, 0, 0, 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule